// File: doc/BRIEF.md
# Timestamp LRU Page Victim Selector

This block keeps a small, fully associative set of page frames. Each frame holds a page number, a valid flag and an age stamp. Page references arrive one per handshake. The block compares each reference against every resident page. On a hit it refreshes the age stamp of the matching frame. On a miss it raises a fault, loads the page into a frame and, when it must throw out a resident page, reports which page that was.

A free-running reference clock advances by one on every accepted reference. The stamp of a frame is loaded from this clock whenever the frame is referenced or filled. When no frame is empty, a sequential scanner visits one frame per cycle and selects the frame whose stamp is oldest, which is the least recently used frame. Hits and fills therefore complete in one cycle. An eviction holds off new references for as many cycles as there are frames. A counter records the total number of faults.

Top module: `lru_victim_select`

## Requirements
- R1: After synchronous reset, `ref_ready` is 1, `hit`, `fault` and `victim_valid` are 0, `fault_count` is 0 and every frame is empty, so the first reference to any page faults.
- R2: A reference to a resident page raises `hit` for exactly one cycle, in the cycle after acceptance, with `fault` low and `fault_count` unchanged. That frame becomes the most recently used.
- R3: A reference to a non-resident page while some frame is empty raises `fault` for one cycle, in the cycle after acceptance, with `victim_valid` low and `ref_ready` staying high. The page goes into the lowest-numbered empty frame.
- R4: A reference to a non-resident page while all frames are full drives `ref_ready` low for exactly NUM_FRAMES cycles after acceptance. `fault` and `victim_valid` then pulse together for one cycle, in the cycle `ref_ready` returns high, with `victim_page` giving the evicted page number.
- R5: The evicted frame is the one referenced least recently. If the frames hold A, B, C and D after the sequence A A A A A B B C C D, a reference to E evicts A.
- R6: `fault_count` rises by exactly one for each fault pulse (fill or eviction) and is otherwise constant.
- R7: The reference clock advances on every accepted reference, so no two valid frames carry equal stamps, and it never wraps within the block's operating span.
- R8: With NUM_FRAMES = 3, starting from reset, the reference string A B C A B D A D B C B produces exactly 5 faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A page reference is offered |
| ref_page | input | PAGE_W | Page number of the offered reference |
| ref_ready | output | 1 | Block can accept a reference (low during a victim scan) |
| hit | output | 1 | One-cycle pulse: the last reference was resident |
| fault | output | 1 | One-cycle pulse: the last reference was not resident |
| victim_valid | output | 1 | One-cycle pulse with `fault` when a resident page was evicted |
| victim_page | output | PAGE_W | Page number of the evicted page, meaningful with `victim_valid` |
| fault_count | output | FCNT_W | Number of faults since reset |

## Verification
The assertions take for granted that fewer than 2^TIME_W references are accepted between resets, so the stamp ordering never wraps. They also take for granted that a page only enters a frame through a miss, so no two frames hold the same page. The stimulus keeps to both rules. It applies only a few hundred references with 16-bit stamps. Every page it offers is either resident or installed by the block itself. Random page numbers come from a small pool, so that hits, fills and evictions all occur often.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Outcome of one accepted reference
    typedef enum logic [1:0] {
        KIND_HIT   = 2'd0,
        KIND_FILL  = 2'd1,
        KIND_EVICT = 2'd2
    } ref_kind_e;

    // Registered response presented at the ports
    typedef struct packed {
        logic hit;
        logic fault;
        logic evict;
    } resp_t;

    localparam resp_t RESP_NONE = '{hit: 1'b0, fault: 1'b0, evict: 1'b0};

    function automatic ref_kind_e classify(input logic resident, input logic all_full);
        if (resident)      return KIND_HIT;
        else if (!all_full) return KIND_FILL;
        else                return KIND_EVICT;
    endfunction

    function automatic resp_t resp_of(input ref_kind_e kind);
        resp_t r;
        r = RESP_NONE;
        case (kind)
            KIND_HIT:   r.hit = 1'b1;
            KIND_FILL:  r.fault = 1'b1;
            default: begin
                r.fault = 1'b1;
                r.evict = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lru_counter.sv
module lru_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (inc) value <= value + W'(1);
    end

    // R6 R7: neither the reference clock nor the fault count may wrap
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        inc |-> (value != {W{1'b1}}));

endmodule

// File: rtl/lru_frame_table.sv
module lru_frame_table #(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    parameter int TIME_W     = 16,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [PAGE_W-1:0]                    look_page,
    output logic                                 look_hit,
    output logic [IDX_W-1:0]                     look_idx,
    output logic                                 full,
    output logic [IDX_W-1:0]                     free_idx,
    input  logic                                 wr_en,
    input  logic                                 wr_load,
    input  logic [IDX_W-1:0]                     wr_idx,
    input  logic [PAGE_W-1:0]                    wr_page,
    input  logic [TIME_W-1:0]                    wr_stamp,
    output logic [NUM_FRAMES-1:0][PAGE_W-1:0]    pages,
    output logic [NUM_FRAMES-1:0][TIME_W-1:0]    stamps
);

    logic [NUM_FRAMES-1:0] valid;
    logic [NUM_FRAMES-1:0] match;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic sel;
        assign sel      = wr_en && (wr_idx == IDX_W'(g));
        assign match[g] = valid[g] && (pages[g] == look_page);

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[g]  <= 1'b0;
                pages[g]  <= '0;
                stamps[g] <= '0;
            end else if (sel) begin
                stamps[g] <= wr_stamp;
                if (wr_load) begin
                    valid[g] <= 1'b1;
                    pages[g] <= wr_page;
                end
            end
        end
    end

    // Lowest-index match and lowest-index empty frame
    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        free_idx = '0;
        full     = &valid;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (match[i]) begin
                look_hit = 1'b1;
                look_idx = IDX_W'(i);
            end
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Newest stamp among valid frames, used only by the checks below
    logic [TIME_W-1:0] newest;
    always_comb begin
        newest = '0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (valid[i] && stamps[i] > newest) newest = stamps[i];
        end
    end

    // R7: every stamp written is strictly newer than all resident stamps
    assert_stamp_fresh_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (|valid)) |-> (wr_stamp > newest));

    // R2: a page is resident in at most one frame
    assert_unique_page_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R3: a fill never targets an occupied frame when an empty one exists
    assert_fill_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_load && !full) |-> !valid[wr_idx]);

endmodule

// File: rtl/lru_age_scanner.sv
module lru_age_scanner #(
    parameter int NUM_FRAMES = 4,
    parameter int TIME_W     = 16,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [NUM_FRAMES-1:0][TIME_W-1:0] stamps,
    output logic                              busy,
    output logic                              done,
    output logic [IDX_W-1:0]                  win_idx
);

    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  best_idx;
    logic [TIME_W-1:0] best_stamp;
    logic              take;

    assign take    = (pos == '0) || (stamps[pos] < best_stamp);
    assign done    = busy && (pos == IDX_W'(NUM_FRAMES - 1));
    assign win_idx = take ? pos : best_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            pos        <= '0;
            best_idx   <= '0;
            best_stamp <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pos  <= '0;
            end
        end else if (done) begin
            busy <= 1'b0;
            pos  <= '0;
        end else begin
            pos        <= pos + IDX_W'(1);
            best_idx   <= win_idx;
            best_stamp <= take ? stamps[pos] : best_stamp;
        end
    end

    // Cycle counter kept only for the length check
    logic [IDX_W:0] span;
    always_ff @(posedge clk) begin
        if (rst || !busy) span <= '0;
        else              span <= span + (IDX_W+1)'(1);
    end

    // R4: a scan lasts exactly NUM_FRAMES cycles
    assert_scan_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (span < (IDX_W+1)'(NUM_FRAMES)));
    assert_scan_end_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    assert_scan_cont_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/lru_victim_select.sv
module lru_victim_select
    import lru_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    parameter int TIME_W     = 16,
    parameter int FCNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              ref_ready,
    output logic              hit,
    output logic              fault,
    output logic              victim_valid,
    output logic [PAGE_W-1:0] victim_page,
    output logic [FCNT_W-1:0] fault_count
);

    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

    logic                              accept;
    logic                              look_hit, full;
    logic [IDX_W-1:0]                  look_idx, free_idx, win_idx;
    logic                              scan_busy, scan_done, scan_start;
    logic [NUM_FRAMES-1:0][PAGE_W-1:0] pages;
    logic [NUM_FRAMES-1:0][TIME_W-1:0] stamps;
    logic [TIME_W-1:0]                 clock_now;
    logic [PAGE_W-1:0]                 pend_page;
    logic [TIME_W-1:0]                 pend_stamp;
    logic                              wr_en, wr_load;
    logic [IDX_W-1:0]                  wr_idx;
    logic [PAGE_W-1:0]                 wr_page;
    logic [TIME_W-1:0]                 wr_stamp;
    ref_kind_e                         kind;
    resp_t                             resp_next, resp_q;

    assign ref_ready = !scan_busy;
    assign accept    = ref_valid && ref_ready;
    assign kind      = classify(look_hit, full);

    lru_frame_table #(
        .NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W), .TIME_W(TIME_W)
    ) u_table (
        .clk(clk), .rst(rst),
        .look_page(ref_page), .look_hit(look_hit), .look_idx(look_idx),
        .full(full), .free_idx(free_idx),
        .wr_en(wr_en), .wr_load(wr_load), .wr_idx(wr_idx),
        .wr_page(wr_page), .wr_stamp(wr_stamp),
        .pages(pages), .stamps(stamps)
    );

    lru_age_scanner #(
        .NUM_FRAMES(NUM_FRAMES), .TIME_W(TIME_W)
    ) u_scan (
        .clk(clk), .rst(rst), .start(scan_start), .stamps(stamps),
        .busy(scan_busy), .done(scan_done), .win_idx(win_idx)
    );

    lru_counter #(.W(TIME_W)) u_clock (
        .clk(clk), .rst(rst), .inc(accept), .value(clock_now)
    );

    lru_counter #(.W(FCNT_W)) u_faults (
        .clk(clk), .rst(rst), .inc(resp_next.fault), .value(fault_count)
    );

    // Table write and response selection
    always_comb begin
        wr_en      = 1'b0;
        wr_load    = 1'b0;
        wr_idx     = '0;
        wr_page    = ref_page;
        wr_stamp   = clock_now;
        scan_start = 1'b0;
        resp_next  = RESP_NONE;
        if (accept) begin
            case (kind)
                KIND_HIT: begin
                    wr_en     = 1'b1;
                    wr_idx    = look_idx;
                    resp_next = resp_of(KIND_HIT);
                end
                KIND_FILL: begin
                    wr_en     = 1'b1;
                    wr_load   = 1'b1;
                    wr_idx    = free_idx;
                    resp_next = resp_of(KIND_FILL);
                end
                default: scan_start = 1'b1;
            endcase
        end else if (scan_done) begin
            wr_en     = 1'b1;
            wr_load   = 1'b1;
            wr_idx    = win_idx;
            wr_page   = pend_page;
            wr_stamp  = pend_stamp;
            resp_next = resp_of(KIND_EVICT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_page   <= '0;
            pend_stamp  <= '0;
            resp_q      <= RESP_NONE;
            victim_page <= '0;
        end else begin
            resp_q <= resp_next;
            if (accept) begin
                pend_page  <= ref_page;
                pend_stamp <= clock_now;
            end
            if (resp_next.evict) victim_page <= pages[win_idx];
        end
    end

    assign hit          = resp_q.hit;
    assign fault        = resp_q.fault;
    assign victim_valid = resp_q.evict;

    // R4: an eviction is always reported as a fault
    assert_evict_is_fault_R4: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> fault);

    // R2: a hit and a fault never appear together
    assert_hit_excl_R2: assert property (@(posedge clk) disable iff (rst)
        hit |-> !fault);

    // R6: the fault count tracks the fault pulses one for one
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_count == $past(fault_count) + FCNT_W'(1)));
    assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !fault |-> $stable(fault_count));

    // R4: a miss on a full table closes the handshake on the next cycle
    assert_ready_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == KIND_EVICT) |=> !ref_ready);

endmodule

// File: tb/lru_victim_select_bench.sv
module lru_victim_select_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NF_BIG     = 4;
    localparam int NF_SMALL   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rv_b = 1'b0, rv_s = 1'b0;
    logic [7:0]  rp_b = '0,   rp_s = '0;
    logic        rdy_b, hit_b, flt_b, vv_b;
    logic        rdy_s, hit_s, flt_s, vv_s;
    logic [7:0]  vp_b, vp_s;
    logic [15:0] fc_b, fc_s;

    lru_victim_select #(.NUM_FRAMES(NF_BIG)) u_lru_victim_select (
        .clk(clk), .rst(rst), .ref_valid(rv_b), .ref_page(rp_b),
        .ref_ready(rdy_b), .hit(hit_b), .fault(flt_b),
        .victim_valid(vv_b), .victim_page(vp_b), .fault_count(fc_b)
    );

    lru_victim_select #(.NUM_FRAMES(NF_SMALL)) u_lru_victim_select_small (
        .clk(clk), .rst(rst), .ref_valid(rv_s), .ref_page(rp_s),
        .ref_ready(rdy_s), .hit(hit_s), .fault(flt_s),
        .victim_valid(vv_s), .victim_page(vp_s), .fault_count(fc_s)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    // Reference model state, index 0 = four frames, 1 = three frames
    logic [7:0] m_page  [2][4];
    bit         m_valid [2][4];
    int         m_stamp [2][4];
    int         m_time  [2];
    int         m_faults[2];
    int         m_nf    [2];

    function automatic logic g_rdy(int s);   return s == 0 ? rdy_b : rdy_s; endfunction
    function automatic logic g_hit(int s);   return s == 0 ? hit_b : hit_s; endfunction
    function automatic logic g_flt(int s);   return s == 0 ? flt_b : flt_s; endfunction
    function automatic logic g_vv(int s);    return s == 0 ? vv_b  : vv_s;  endfunction
    function automatic logic [7:0] g_vp(int s);  return s == 0 ? vp_b : vp_s; endfunction
    function automatic logic [15:0] g_fc(int s); return s == 0 ? fc_b : fc_s; endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 4; i++) begin
                m_page[s][i]  = '0;
                m_valid[s][i] = 1'b0;
                m_stamp[s][i] = 0;
            end
            m_time[s]   = 0;
            m_faults[s] = 0;
        end
    endtask

    // Expected outcome of one reference, computed from the requirements
    task automatic model_ref(input int s, input logic [7:0] pg,
                             output bit eh, output bit ef, output bit ev,
                             output logic [7:0] evp, output int lat);
        int idx;
        idx = -1;
        eh = 0; ef = 0; ev = 0; evp = '0; lat = 1;
        for (int i = 0; i < m_nf[s]; i++)
            if (m_valid[s][i] && m_page[s][i] == pg) idx = i;
        if (idx >= 0) begin
            eh = 1;
        end else begin
            ef = 1;
            m_faults[s]++;
            for (int i = m_nf[s] - 1; i >= 0; i--)
                if (!m_valid[s][i]) idx = i;
            if (idx < 0) begin
                idx = 0;
                for (int i = 1; i < m_nf[s]; i++)
                    if (m_stamp[s][i] < m_stamp[s][idx]) idx = i;
                ev  = 1;
                evp = m_page[s][idx];
                lat = m_nf[s] + 1;
            end
            m_page[s][idx]  = pg;
            m_valid[s][idx] = 1'b1;
        end
        m_stamp[s][idx] = m_time[s];
        m_time[s]++;
    endtask

    task automatic run_ref(input int s, input logic [7:0] pg, output logic [7:0] got_vp);
        bit eh, ef, ev, seen, low_ok;
        logic [7:0] evp;
        int lat, got_lat;
        string rq;
        model_ref(s, pg, eh, ef, ev, evp, lat);
        rq = eh ? "R2" : (ev ? "R5 R7" : "R3");
        @(negedge clk);
        while (!g_rdy(s)) @(negedge clk);
        if (s == 0) begin rv_b = 1'b1; rp_b = pg; end
        else        begin rv_s = 1'b1; rp_s = pg; end
        @(posedge clk);
        #1;
        rv_b = 1'b0;
        rv_s = 1'b0;
        seen = 0; low_ok = 1; got_lat = 0;
        for (int k = 1; k <= 12 && !seen; k++) begin
            @(negedge clk);
            if (g_hit(s) || g_flt(s)) begin
                seen = 1;
                got_lat = k;
            end else if (g_rdy(s)) begin
                low_ok = 0;
            end
        end
        got_vp = g_vp(s);
        check(got_lat == lat, ev ? "R4" : rq, "response cycle", got_lat, lat);
        check(g_hit(s) == eh, rq, "hit", int'(g_hit(s)), int'(eh));
        check(g_flt(s) == ef, rq, "fault", int'(g_flt(s)), int'(ef));
        check(g_vv(s) == ev, ev ? "R4" : "R3", "victim_valid", int'(g_vv(s)), int'(ev));
        if (ev) begin
            check(g_vp(s) == evp, "R5 R7", "victim_page", int'(g_vp(s)), int'(evp));
            check(low_ok && g_rdy(s), "R4", "ready low during scan", int'(low_ok), 1);
        end else begin
            check(g_rdy(s) == 1'b1, rq, "ready after hit or fill", int'(g_rdy(s)), 1);
        end
        check(g_fc(s) == 16'(m_faults[s]), "R6", "fault_count",
              int'(g_fc(s)), m_faults[s]);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] vp;
        m_nf[0] = NF_BIG;
        m_nf[1] = NF_SMALL;
        model_reset();
        void'($urandom(32'd537));

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            check(g_rdy(s) == 1'b1, "R1", "ready after reset", int'(g_rdy(s)), 1);
            check(!g_hit(s) && !g_flt(s) && !g_vv(s), "R1", "pulses after reset",
                  int'({g_hit(s), g_flt(s), g_vv(s)}), 0);
            check(g_fc(s) == '0, "R1", "fault_count after reset", int'(g_fc(s)), 0);
        end

        // R5: A x5, B B, C C, D, then E must evict A (pages 0x0A..0x0E)
        repeat (5) run_ref(0, 8'h0A, vp);
        repeat (2) run_ref(0, 8'h0B, vp);
        repeat (2) run_ref(0, 8'h0C, vp);
        run_ref(0, 8'h0D, vp);
        check(fc_b == 16'd4, "R3", "four fills fault", int'(fc_b), 4);
        run_ref(0, 8'h0E, vp);
        check(vp == 8'h0A, "R5", "E evicts A", int'(vp), 8'h0A);

        // R8: three frames, string A B C A B D A D B C B gives 5 faults
        begin
            logic [7:0] seq [11];
            seq = '{8'hA, 8'hB, 8'hC, 8'hA, 8'hB, 8'hD, 8'hA, 8'hD, 8'hB, 8'hC, 8'hB};
            for (int i = 0; i < 11; i++) run_ref(1, seq[i], vp);
        end
        check(fc_s == 16'd5, "R8", "faults for reference string", int'(fc_s), 5);

        // Random mix on four frames, small page pool, idle gaps between references
        for (int n = 0; n < 300; n++) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            run_ref(0, 8'($urandom_range(0, 6)), vp);
        end

        // R7: repeated hits on one page keep it out of eviction
        for (int n = 0; n < 6; n++) begin
            run_ref(0, 8'h33, vp);
            run_ref(0, 8'($urandom_range(64, 80)), vp);
        end
        check(vp != 8'h33, "R7", "recent page not evicted", int'(vp), -1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule